// File: doc/BRIEF.md
# Double-Buffered Register Context Manager

This block holds two banked copies of a pipeline cluster's register state, so that the state for the next draw can be written while the previous draw still runs on the other copy. One copy is the setup context and receives register writes. The other copy, or the same one after a start event, is the execution context, which the pipeline stage reads through a read port with one cycle of latency. Each context has a free flag. A start event clears the flag of the setup context and hands that context to execution. A context-done event sets the flag again once the work that used the context has finished.

An end event rolls the contexts over. It waits until the other context is free. It then copies, one register per cycle, every register dirtied in the setup context into the other context, and that context becomes the new setup context. A small set of unbanked registers has a single copy. A write to one of them waits for an external idle indication. The parameter `IS_2D` selects which of the two event families the instance obeys, so a 3D instance and a 2D instance can each roll over on its own.

Top module: `regctx_dual_bank`

## Requirements
- R1: After synchronous reset, setup_ctx and exec_ctx are 0, ctx_free is 2'b11 and copy_busy is 0.
- R2: A banked write (wr_unbanked=0) is accepted only while the setup context is free and no copy is running. Otherwise wr_ready is low. An accepted write stores wr_data at wr_addr of the setup context and marks that register dirty.
- R3: An accepted start event clears the free bit of the setup context and makes it the execution context from the next cycle.
- R4: A done event sets the free bit of the older busy context. That is the non-executing context if it is busy, otherwise the executing one. Done events are never held off.
- R5: An end event holds evt_ready low until the other context is free. If no register is dirty, setup_ctx toggles on acceptance and copy_busy stays low.
- R6: With N dirty registers, copy_busy is high for exactly N cycles after the end event is accepted. During that time one register is copied per cycle into the other context. Then setup_ctx toggles and the source dirty mask is empty.
- R7: A banked write accepted in the same cycle as an end event is part of the copy.
- R8: While copy_busy is high, start and end events are held with evt_ready low.
- R9: An unbanked write is accepted only while idle_i is high. Its single copy, addressed by wr_addr[UB_W-1:0], reads back the same whatever the contexts are.
- R10: The value of register rd_addr appears on rd_data one cycle after it is requested. The value comes from the execution context, or from the unbanked file when rd_unbanked=1.
- R11: evt_code bit 2 selects the family (0 = 3D, 1 = 2D) and bits 1:0 select the kind (1 start, 2 done, 3 end, 0 none). Codes of the other family, and kind 0, have no effect and evt_ready stays high for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Register write request |
| wr_unbanked | input | 1 | Write targets the unbanked file |
| wr_addr | input | IDX_W | Register index |
| wr_data | input | DATA_W | Write data |
| wr_ready | output | 1 | Write accepted this cycle |
| evt_valid | input | 1 | Event request |
| evt_code | input | 3 | Family bit and event kind |
| evt_ready | output | 1 | Event accepted this cycle |
| idle_i | input | 1 | Pipeline idle indication for unbanked writes |
| rd_unbanked | input | 1 | Read from the unbanked file |
| rd_addr | input | IDX_W | Stage read index |
| rd_data | output | DATA_W | Stage read data, one cycle later |
| setup_ctx | output | 1 | Context that receives writes |
| exec_ctx | output | 1 | Context being executed |
| ctx_free | output | 2 | Free flag per context |
| copy_busy | output | 1 | Rollover copy in progress |

## Verification
Two functions can fall in the same cycle: a banked write into the setup context and an end event that snapshots the dirty mask of that context. The bench provokes this by leaving both contexts free, with one register already dirty, and then driving a write and an end event in one cycle. It judges the result by the copy length on copy_busy and by reading both registers back from the rolled-over context after a later start. A behavioural model predicts every output on every cycle. It also covers the stall cases: a write against a busy setup context, an end event against a busy other context, and a start event during a copy.

// File: rtl/regctx_pkg.sv
package regctx_pkg;
  // decoded event for the family this instance serves
  typedef struct packed {
    logic start;
    logic done;
    logic fin;
  } ev_dec_t;
  localparam logic [1:0] EV_START = 2'd1;
  localparam logic [1:0] EV_DONE  = 2'd2;
  localparam logic [1:0] EV_END   = 2'd3;
endpackage

// File: rtl/regctx_evt_decode.sv
module regctx_evt_decode import regctx_pkg::*; #(
  parameter bit IS_2D = 1'b0
) (
  input  logic       evt_valid,
  input  logic [2:0] evt_code,
  output ev_dec_t    dec
);
  logic mine;
  generate
    if (IS_2D) begin : g_2d
      assign mine = evt_valid && evt_code[2];
    end else begin : g_3d
      assign mine = evt_valid && !evt_code[2];
    end
  endgenerate

  always_comb begin
    dec.start = mine && (evt_code[1:0] == EV_START);
    dec.done  = mine && (evt_code[1:0] == EV_DONE);
    dec.fin   = mine && (evt_code[1:0] == EV_END);
  end
endmodule

// File: rtl/regctx_copy_engine.sv
module regctx_copy_engine #(
  parameter int NREGS = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [NREGS-1:0] mask,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [NREGS-1:0] ONE = {{(NREGS-1){1'b0}}, 1'b1};
  logic [NREGS-1:0] rem;

  // lowest pending register goes first
  always_comb begin
    idx = '0;
    for (int i = NREGS - 1; i >= 0; i--)
      if (rem[i]) idx = IDX_W'(i);
  end

  assign last = ~|(rem & (rem - ONE));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      rem  <= '0;
    end else if (launch) begin
      rem  <= mask;
      busy <= |mask;
    end else if (busy) begin
      rem <= rem & ~(ONE << idx);
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/regctx_store.sv
module regctx_store #(
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  parameter int NUB    = 4,
  parameter int IDX_W  = 5,
  parameter int UB_W   = 2
) (
  input  logic              clk,
  input  logic              bwe,
  input  logic [IDX_W:0]    bwaddr,
  input  logic [DATA_W-1:0] bwdata,
  input  logic              uwe,
  input  logic [UB_W-1:0]   uwaddr,
  input  logic [DATA_W-1:0] uwdata,
  input  logic [IDX_W:0]    craddr,
  output logic [DATA_W-1:0] cdata,
  input  logic              rd_ub,
  input  logic [IDX_W:0]    rdaddr,
  input  logic [UB_W-1:0]   rd_ub_addr,
  output logic [DATA_W-1:0] rdata
);
  // both contexts in one array, context bit on top of the index
  logic [DATA_W-1:0] bank_mem [2*NREGS];
  logic [DATA_W-1:0] ub_mem   [NUB];

  always_ff @(posedge clk) begin
    if (bwe) bank_mem[bwaddr] <= bwdata;
  end

  always_ff @(posedge clk) begin
    if (uwe) ub_mem[uwaddr] <= uwdata;
  end

  assign cdata = bank_mem[craddr];

  always_ff @(posedge clk) begin
    rdata <= rd_ub ? ub_mem[rd_ub_addr] : bank_mem[rdaddr];
  end
endmodule

// File: rtl/regctx_dual_bank.sv
module regctx_dual_bank import regctx_pkg::*; #(
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  parameter int NUB    = 4,
  parameter bit IS_2D  = 1'b0,
  localparam int IDX_W = $clog2(NREGS),
  localparam int UB_W  = (NUB > 1) ? $clog2(NUB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              wr_unbanked,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              evt_valid,
  input  logic [2:0]        evt_code,
  output logic              evt_ready,
  input  logic              idle_i,
  input  logic              rd_unbanked,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              setup_ctx,
  output logic              exec_ctx,
  output logic [1:0]        ctx_free,
  output logic              copy_busy
);
  localparam logic [NREGS-1:0] ONE = {{(NREGS-1){1'b0}}, 1'b1};

  logic                  s_ctx, e_ctx;
  logic [1:0]            free;
  logic [1:0][NREGS-1:0] dirty;
  ev_dec_t               dec;
  logic                  busy, last;
  logic [IDX_W-1:0]      cidx;
  logic [DATA_W-1:0]     cdata;
  logic                  bank_wr, ub_wr, end_go;
  logic [NREGS-1:0]      wr_bit, launch_mask;

  regctx_evt_decode #(.IS_2D(IS_2D)) u_dec (
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .dec       (dec)
  );

  assign wr_ready  = wr_unbanked ? idle_i : (free[s_ctx] && !busy);
  assign bank_wr   = wr_valid && wr_ready && !wr_unbanked;
  assign ub_wr     = wr_valid && wr_ready && wr_unbanked;
  assign evt_ready = !((dec.start && busy) ||
                       (dec.fin && (busy || !free[~s_ctx])));
  assign end_go    = dec.fin && evt_ready;

  // a write landing in the same cycle joins the snapshot
  assign wr_bit      = ONE << wr_addr;
  assign launch_mask = dirty[s_ctx] | (bank_wr ? wr_bit : '0);

  regctx_copy_engine #(.NREGS(NREGS), .IDX_W(IDX_W)) u_copy (
    .clk    (clk),
    .rst    (rst),
    .launch (end_go),
    .mask   (launch_mask),
    .busy   (busy),
    .idx    (cidx),
    .last   (last)
  );

  regctx_store #(
    .NREGS(NREGS), .DATA_W(DATA_W), .NUB(NUB), .IDX_W(IDX_W), .UB_W(UB_W)
  ) u_store (
    .clk        (clk),
    .bwe        (bank_wr || busy),
    .bwaddr     (busy ? {~s_ctx, cidx} : {s_ctx, wr_addr}),
    .bwdata     (busy ? cdata : wr_data),
    .uwe        (ub_wr),
    .uwaddr     (wr_addr[UB_W-1:0]),
    .uwdata     (wr_data),
    .craddr     ({s_ctx, cidx}),
    .cdata      (cdata),
    .rd_ub      (rd_unbanked),
    .rdaddr     ({e_ctx, rd_addr}),
    .rd_ub_addr (rd_addr[UB_W-1:0]),
    .rdata      (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ctx <= 1'b0;
      e_ctx <= 1'b0;
      free  <= 2'b11;
    end else begin
      if (dec.start && evt_ready) begin
        free[s_ctx] <= 1'b0;
        e_ctx       <= s_ctx;
      end
      if (dec.done) begin
        if (!free[~e_ctx]) free[~e_ctx] <= 1'b1;
        else               free[e_ctx]  <= 1'b1;
      end
      if ((end_go && launch_mask == '0) || (busy && last))
        s_ctx <= ~s_ctx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dirty <= '0;
    end else begin
      if (bank_wr) dirty[s_ctx] <= dirty[s_ctx] | wr_bit;
      if (busy && last) dirty[s_ctx] <= '0;
    end
  end

  assign setup_ctx = s_ctx;
  assign exec_ctx  = e_ctx;
  assign ctx_free  = free;
  assign copy_busy = busy;
endmodule

// File: rtl/regctx_checker.sv
module regctx_checker #(
  parameter bit IS_2D = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_valid,
  input logic       wr_unbanked,
  input logic       wr_ready,
  input logic       evt_valid,
  input logic [2:0] evt_code,
  input logic       evt_ready,
  input logic       idle_i,
  input logic       setup_ctx,
  input logic       exec_ctx,
  input logic [1:0] ctx_free,
  input logic       copy_busy
);
  localparam logic [2:0] C_START = {IS_2D, 2'b01};
  localparam logic [2:0] C_END   = {IS_2D, 2'b11};

  AST_WR_STALL: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_unbanked && (!ctx_free[setup_ctx] || copy_busy)) |-> !wr_ready); // R2

  AST_START_CLAIMS: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == C_START && evt_ready) |=>
      (exec_ctx == $past(setup_ctx)) && !ctx_free[exec_ctx]); // R3

  AST_END_WAITS: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == C_END && !ctx_free[~setup_ctx]) |-> !evt_ready); // R5

  AST_COPY_FLIPS: assert property (@(posedge clk) disable iff (rst)
    $fell(copy_busy) |-> (setup_ctx != $past(setup_ctx))); // R6

  AST_COPY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (copy_busy && evt_valid && (evt_code == C_START || evt_code == C_END)) |-> !evt_ready); // R8

  AST_UB_IDLE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_unbanked && !idle_i) |-> !wr_ready); // R9
endmodule

bind regctx_dual_bank regctx_checker #(.IS_2D(IS_2D)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_unbanked(wr_unbanked),
  .wr_ready(wr_ready), .evt_valid(evt_valid), .evt_code(evt_code),
  .evt_ready(evt_ready), .idle_i(idle_i), .setup_ctx(setup_ctx),
  .exec_ctx(exec_ctx), .ctx_free(ctx_free), .copy_busy(copy_busy)
);

// File: tb/tb_regctx_dual_bank.sv
`timescale 1ns/1ps
module tb_regctx_dual_bank;
  localparam int NR = 32;
  localparam int NU = 4;
  localparam bit TB_2D = 1'b0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 0, wr_unbanked = 0, evt_valid = 0, idle_i = 1, rd_unbanked = 0;
  logic [4:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [2:0] evt_code = 0;
  logic wr_ready, evt_ready, setup_ctx, exec_ctx, copy_busy;
  logic [1:0] ctx_free;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  regctx_dual_bank #(.NREGS(NR), .DATA_W(32), .NUB(NU), .IS_2D(TB_2D)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_unbanked(wr_unbanked),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_ready(evt_ready),
    .idle_i(idle_i), .rd_unbanked(rd_unbanked), .rd_addr(rd_addr),
    .rd_data(rd_data), .setup_ctx(setup_ctx), .exec_ctx(exec_ctx),
    .ctx_free(ctx_free), .copy_busy(copy_busy)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  string focus = "R1";

  // behavioural reference
  int m_mem [2][NR];
  bit m_known [2][NR];
  int m_ub [NU];
  bit m_ubk [NU];
  bit [NR-1:0] m_dirty [2];
  bit [NR-1:0] m_cmask;
  bit [1:0] m_free;
  int m_s, m_e, m_left;
  int exp_rd;
  bit exp_rd_known;
  int busy_seen;

  function automatic void chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s): actual %0d expected %0d", tag, focus, act, exp);
    end
  endfunction

  function automatic void model_reset();
    for (int c = 0; c < 2; c++) begin
      m_dirty[c] = '0;
      for (int i = 0; i < NR; i++) m_known[c][i] = 0;
    end
    for (int i = 0; i < NU; i++) m_ubk[i] = 0;
    m_free = 2'b11; m_s = 0; m_e = 0; m_left = 0; exp_rd_known = 0;
  endfunction

  task automatic cyc(bit wv, bit wub, int wa, int wd, bit ev, int ec, bit idl, bit ru, int ra);
    bit mine, busy, wrdy, erdy, wfire;
    int kind;
    wr_valid = wv; wr_unbanked = wub; wr_addr = wa[4:0]; wr_data = wd;
    evt_valid = ev; evt_code = ec[2:0]; idle_i = idl; rd_unbanked = ru; rd_addr = ra[4:0];
    #1;
    busy = (m_left > 0);
    mine = ev && (ec[2] == TB_2D);
    kind = ec & 3;
    wrdy = wub ? idl : (m_free[m_s] && !busy);
    erdy = !(mine && ((kind == 1 && busy) || (kind == 3 && (busy || !m_free[1-m_s]))));
    // outputs settled after the last edge
    chk("R5", setup_ctx, m_s);
    chk("R3", exec_ctx, m_e);
    chk("R4", ctx_free, m_free);
    chk("R6", copy_busy, busy);
    chk("R2", wr_ready, wrdy);
    chk("R8", evt_ready, erdy);
    if (exp_rd_known) chk("R10", rd_data, exp_rd);
    if (copy_busy) busy_seen++;
    // read result due after the coming edge
    if (ru) begin
      exp_rd_known = m_ubk[ra % NU]; exp_rd = m_ub[ra % NU];
    end else begin
      exp_rd_known = m_known[m_e][ra] && !(busy && m_e != m_s);
      exp_rd = m_mem[m_e][ra];
    end
    // next state
    wfire = wv && wrdy;
    if (wfire && wub) begin
      m_ub[wa % NU] = wd; m_ubk[wa % NU] = 1;
    end else if (wfire) begin
      m_mem[m_s][wa] = wd; m_known[m_s][wa] = 1; m_dirty[m_s][wa] = 1'b1;
    end
    if (busy) begin
      m_left--;
      if (m_left == 0) begin
        for (int i = 0; i < NR; i++)
          if (m_cmask[i]) begin
            m_mem[1-m_s][i] = m_mem[m_s][i];
            m_known[1-m_s][i] = m_known[m_s][i];
          end
        m_dirty[m_s] = '0;
        m_s = 1 - m_s;
      end
    end
    if (mine && erdy) begin
      if (kind == 1) begin
        m_free[m_s] = 0; m_e = m_s;
      end else if (kind == 2) begin
        if (!m_free[1-m_e]) m_free[1-m_e] = 1; else m_free[m_e] = 1;
      end else if (kind == 3) begin
        if (m_dirty[m_s] == '0) m_s = 1 - m_s;
        else begin
          m_cmask = m_dirty[m_s];
          m_left = $countones(m_dirty[m_s]);
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
  endtask
  task automatic wr(int a, int d);  cyc(1, 0, a, d, 0, 0, 1, 0, 0); endtask
  task automatic evt(int c);        cyc(0, 0, 0, 0, 1, c, 1, 0, 0); endtask
  task automatic rd(int a);         cyc(0, 0, 0, 0, 0, 0, 1, 0, a); endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    // R1 reset state
    #1;
    chk("R1", setup_ctx, 0); chk("R1", exec_ctx, 0);
    chk("R1", ctx_free, 3);  chk("R1", copy_busy, 0);
    idle(1);

    focus = "R2 R10";
    for (int i = 0; i < 6; i++) wr(i, 100 + i);
    for (int i = 0; i < 6; i++) rd(i);

    focus = "R3";
    evt(1);
    wr(7, 77);            // setup context busy: stalled
    rd(3);

    focus = "R6 R8";
    evt(3);               // other context free: copy of 6 registers
    busy_seen = 0;
    evt(1);               // held during the copy
    evt(3);               // held during the copy
    idle(6);
    chk("R6", busy_seen, 6);

    focus = "R4";
    evt(2);               // frees the executing context 0
    wr(10, 210); wr(11, 211);
    rd(0);
    evt(1);               // context 1 goes to execution
    rd(2); rd(10);

    focus = "R5";
    evt(3);               // copy 10, 11 into context 0
    idle(3);
    wr(20, 320);
    evt(1);               // both contexts busy now
    wr(21, 321);          // stalled
    for (int i = 0; i < 3; i++) evt(3);   // held: other context busy
    evt(2);               // older context 1 finishes
    evt(2);               // context 0 finishes

    focus = "R7";
    cyc(1, 0, 22, 422, 1, 3, 1, 0, 0);    // write and end in one cycle
    busy_seen = 0;
    idle(4);
    chk("R7", busy_seen, 2);
    evt(1);
    rd(20); rd(22); rd(2);

    focus = "R5";
    evt(2);
    evt(3);               // empty mask: immediate flip
    idle(2);

    focus = "R9";
    cyc(1, 1, 2, 555, 0, 0, 0, 0, 0);     // idle low: stalled
    cyc(1, 1, 2, 555, 0, 0, 0, 0, 0);
    cyc(1, 1, 2, 555, 0, 0, 1, 0, 0);     // accepted
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 2);
    evt(1);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 2);

    focus = "R11";
    evt(5); evt(6); evt(7); evt(4); evt(0);
    rd(20);
    idle(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule